// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error Flags

This block receives asynchronous serial characters on a single line. A one-cycle enable pulse from an external baud generator paces it at sixteen pulses per bit time. While idle it waits for the line to fall. It confirms the start bit at mid-bit and then takes every following bit at its mid-bit point. It assembles 7 or 8 data bits, least significant first. An optional parity bit follows, which may be even or odd. The frame ends with one or two stop bits.

When the first stop bit has been sampled, the character moves from the shift register into a one-entry holding buffer. The next character can then shift in while the host still holds the previous one. In that same clock cycle the buffer-full flag rises, the overrun, parity and framing flags update, and a one-cycle interrupt pulse is raised. A host read strobe empties the buffer. A separate clear strobe resets the error flags.

Configuration inputs are expected to stay constant while a frame is in progress.

Top module: `serial_rx_unit`

## Requirements
- R1: After synchronous reset, rx_full, rx_irq, err_overrun, err_parity and err_frame are 0 and rx_data is 0x00.
- R2: Each bit lasts 16 tick16 pulses and is sampled at its middle. Data bits arrive least significant first, so an 8-bit frame carrying bits 1,1,0,1,0,0,1,0 in line order yields rx_data = 0x4B.
- R3: rx_full, rx_data and the three error flags all update in the same clock cycle. In that cycle rx_irq is 1 for exactly one clock, and only when rx_full rises from 0 to 1.
- R4: When cfg_len8 = 0, seven data bits are received and rx_data[7] reads 0.
- R5: When cfg_par_en = 1, a parity bit follows the data. With cfg_par_odd = 0 the data plus parity hold an even count of ones; with cfg_par_odd = 1 they hold an odd count. A mismatch sets err_parity.
- R6: err_frame is set when the first stop bit samples as 0.
- R7: A low pulse on rx_in is rejected as a false start when the line is back at 1 at the 8th tick after the fall is seen. Such a pulse changes neither rx_full nor rx_data.
- R8: With cfg_stop2 = 1, the receiver waits out a second stop bit but does not check it. A 0 in that bit sets no flag.
- R9: A character that completes while rx_full is 1 sets err_overrun. The buffer keeps its old contents and no interrupt is raised. This holds even if rd_strobe arrives in the same cycle.
- R10: The error flags stay set until err_clr is pulsed. err_clr has no effect on rx_full or rx_data.
- R11: A rd_strobe pulse while rx_full is 1 clears rx_full on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit |
| rx_in | input | 1 | Asynchronous serial line, idles at 1 |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | 1: a parity bit follows the data |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| rd_strobe | input | 1 | Host read of the buffer, clears rx_full |
| err_clr | input | 1 | Clears all three error flags |
| rx_data | output | 8 | Buffered character |
| rx_full | output | 1 | Buffer holds an unread character |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |
| err_overrun | output | 1 | Sticky overrun flag |
| err_parity | output | 1 | Sticky parity error flag |
| err_frame | output | 1 | Sticky framing error flag |

## Verification
The bench builds the block with its default parameters: 16 samples per bit and a two-stage input synchronizer. It drives tick16 once every 4 clocks, so one bit lasts 64 clocks and each mid-bit sample falls about 35 clocks into its bit. That margin lets the bench shape stop bits that are low only for their first part. It can then hit the mid-bit sample and still return the line high before a false start could be confirmed. This covers framing errors, unchecked second stop bits and start rejection, without one case bleeding into the next frame.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP1,
        RX_STOP2
    } rx_state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              par_bad;
        logic              frm_bad;
    } rx_char_t;

    // index of the last data bit for the chosen character length
    function automatic logic [3:0] last_data_idx(input logic len8);
        return len8 ? 4'd7 : 4'd6;
    endfunction

    // right-aligned character from the LSB-first shift register
    function automatic logic [CHAR_W-1:0] align_char(input logic len8,
                                                     input logic [CHAR_W-1:0] sr);
        return len8 ? sr : {1'b0, sr[CHAR_W-1:1]};
    endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int N = (STAGES < 1) ? 1 : STAGES;

    logic [N-1:0] q;

    generate
        if (N == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b1;
                else     q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= {q[N-2:0], din};
            end
        end
    endgenerate

    assign dout = q[N-1];
endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
    import serial_rx_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     line,
    input  logic     len8,
    input  logic     par_en,
    input  logic     par_odd,
    input  logic     stop2,
    output logic     done,
    output rx_char_t chr
);
    localparam int CW = (OS_RATE > 2) ? $clog2(OS_RATE) : 1;
    localparam logic [CW-1:0] MID_LAST = CW'(OS_RATE / 2 - 1);
    localparam logic [CW-1:0] BIT_LAST = CW'(OS_RATE - 1);

    rx_state_e         st;
    logic [CW-1:0]     cnt;
    logic [3:0]        nbit;
    logic [CHAR_W-1:0] sr;
    logic              acc;
    logic              at_bit;

    // one full bit period has elapsed since the previous sample
    always_comb at_bit = tick && (cnt == BIT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= RX_IDLE;
            cnt  <= '0;
            nbit <= '0;
            sr   <= '0;
            acc  <= 1'b0;
            done <= 1'b0;
            chr  <= '0;
        end else begin
            done <= 1'b0;
            if (tick && st != RX_IDLE && !at_bit && !(st == RX_START && cnt == MID_LAST))
                cnt <= cnt + CW'(1);
            unique case (st)
                RX_IDLE: begin
                    if (tick && !line) begin
                        st  <= RX_START;
                        cnt <= '0;
                    end
                end
                RX_START: begin
                    if (tick && cnt == MID_LAST) begin
                        cnt <= '0;
                        if (!line) begin
                            st   <= RX_DATA;
                            nbit <= '0;
                            acc  <= 1'b0;
                        end else begin
                            st <= RX_IDLE;
                        end
                    end
                end
                RX_DATA: begin
                    if (at_bit) begin
                        cnt  <= '0;
                        sr   <= {line, sr[CHAR_W-1:1]};
                        acc  <= acc ^ line;
                        nbit <= nbit + 4'd1;
                        if (nbit == last_data_idx(len8))
                            st <= par_en ? RX_PARITY : RX_STOP1;
                    end
                end
                RX_PARITY: begin
                    if (at_bit) begin
                        cnt <= '0;
                        acc <= acc ^ line;
                        st  <= RX_STOP1;
                    end
                end
                RX_STOP1: begin
                    if (at_bit) begin
                        cnt         <= '0;
                        done        <= 1'b1;
                        chr.data    <= align_char(len8, sr);
                        chr.par_bad <= par_en && (acc ^ par_odd);
                        chr.frm_bad <= !line;
                        st          <= stop2 ? RX_STOP2 : RX_IDLE;
                    end
                end
                RX_STOP2: begin
                    if (at_bit) begin
                        cnt <= '0;
                        st  <= RX_IDLE;
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/serial_rx_holdbuf.sv
module serial_rx_holdbuf
    import serial_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_char_t          chr,
    input  logic              rd_strobe,
    input  logic              err_clr,
    output logic [CHAR_W-1:0] data,
    output logic              full,
    output logic              irq,
    output logic              ovr,
    output logic              par,
    output logic              frm
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            full <= 1'b0;
            irq  <= 1'b0;
            ovr  <= 1'b0;
            par  <= 1'b0;
            frm  <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (rd_strobe) full <= 1'b0;
            if (err_clr) begin
                ovr <= 1'b0;
                par <= 1'b0;
                frm <= 1'b0;
            end
            if (done) begin
                if (chr.par_bad) par <= 1'b1;
                if (chr.frm_bad) frm <= 1'b1;
                if (full) begin
                    ovr <= 1'b1;
                end else begin
                    data <= chr.data;
                    full <= 1'b1;
                    irq  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
    import serial_rx_pkg::*;
#(
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick16,
    input  logic        rx_in,
    input  logic        cfg_len8,
    input  logic        cfg_par_en,
    input  logic        cfg_par_odd,
    input  logic        cfg_stop2,
    input  logic        rd_strobe,
    input  logic        err_clr,
    output logic [7:0]  rx_data,
    output logic        rx_full,
    output logic        rx_irq,
    output logic        err_overrun,
    output logic        err_parity,
    output logic        err_frame
);
    logic     line_s;
    logic     chr_done;
    rx_char_t chr;

    serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_in),
        .dout (line_s)
    );

    serial_rx_framer #(.OS_RATE(OS_RATE)) u_framer (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick16),
        .line    (line_s),
        .len8    (cfg_len8),
        .par_en  (cfg_par_en),
        .par_odd (cfg_par_odd),
        .stop2   (cfg_stop2),
        .done    (chr_done),
        .chr     (chr)
    );

    serial_rx_holdbuf u_buf (
        .clk       (clk),
        .rst       (rst),
        .done      (chr_done),
        .chr       (chr),
        .rd_strobe (rd_strobe),
        .err_clr   (err_clr),
        .data      (rx_data),
        .full      (rx_full),
        .irq       (rx_irq),
        .ovr       (err_overrun),
        .par       (err_parity),
        .frm       (err_frame)
    );
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_len8,
    input logic       rd_strobe,
    input logic       err_clr,
    input logic [7:0] rx_data,
    input logic       rx_full,
    input logic       rx_irq,
    input logic       err_overrun,
    input logic       err_parity,
    input logic       err_frame
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!rx_full && !rx_irq && !err_overrun && !err_parity && !err_frame));

    a_r3_irq_on_full_rise: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> (rx_full && !$past(rx_full)));

    a_r3_irq_single_cycle: assert property (@(posedge clk) disable iff (rst)
        rx_irq |=> !rx_irq);

    a_r4_bit7_zero: assert property (@(posedge clk) disable iff (rst)
        ($rose(rx_full) && !cfg_len8) |-> !rx_data[7]);

    a_r9_overrun_keeps_data: assert property (@(posedge clk) disable iff (rst)
        $rose(err_overrun) |-> ($stable(rx_data) && !rx_irq));

    a_r10_parity_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_parity && !err_clr) |=> err_parity);

    a_r10_frame_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_frame && !err_clr) |=> err_frame);

    a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_overrun && !err_clr) |=> err_overrun);

    a_r11_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && rx_full) |=> !rx_full);
endmodule

bind serial_rx_unit serial_rx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_len8    (cfg_len8),
    .rd_strobe   (rd_strobe),
    .err_clr     (err_clr),
    .rx_data     (rx_data),
    .rx_full     (rx_full),
    .rx_irq      (rx_irq),
    .err_overrun (err_overrun),
    .err_parity  (err_parity),
    .err_frame   (err_frame)
);

// File: tb/test_serial_rx_unit.sv
`timescale 1ns/1ps
module test_serial_rx_unit;
    localparam int OS     = 16;
    localparam int TDIV   = 4;
    localparam int BITCLK = OS * TDIV;

    typedef struct {
        logic [7:0] data;
        logic       par;
        logic       frm;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick16 = 1'b0;
    logic rx_line = 1'b1;
    logic cfg_len8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
    logic rd_strobe = 1'b0, err_clr = 1'b0;
    logic [7:0] rx_data;
    logic rx_full, rx_irq, err_overrun, err_parity, err_frame;

    int n_chk = 0;
    int n_fail = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    serial_rx_unit i_serial_rx_unit (
        .clk(clk), .rst(rst), .tick16(tick16), .rx_in(rx_line),
        .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .rd_strobe(rd_strobe), .err_clr(err_clr),
        .rx_data(rx_data), .rx_full(rx_full), .rx_irq(rx_irq),
        .err_overrun(err_overrun), .err_parity(err_parity), .err_frame(err_frame)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // tick generator: one pulse every TDIV clocks
    initial begin
        int c = 0;
        forever begin
            @(posedge clk);
            tick16 <= (c == TDIV - 1);
            c = (c == TDIV - 1) ? 0 : c + 1;
        end
    end

    task automatic drive_bit(input logic v, input int low_clks);
        rx_line <= v;
        if (low_clks > 0 && v == 1'b0) begin
            repeat (low_clks) @(posedge clk);
            rx_line <= 1'b1;
            repeat (BITCLK - low_clks) @(posedge clk);
        end else begin
            repeat (BITCLK) @(posedge clk);
        end
    endtask

    // driver: pushes the expected item, then serialises the frame
    task automatic send_frame(input logic [7:0] d, input bit bad_par,
                              input bit low_stop1, input bit low_stop2, input bit expect_it);
        int nb;
        logic [7:0] dm;
        logic pb;
        exp_t e;
        nb = cfg_len8 ? 8 : 7;
        dm = cfg_len8 ? d : {1'b0, d[6:0]};
        pb = (^dm) ^ cfg_par_odd ^ bad_par;
        e.data = dm;
        e.par  = bad_par && cfg_par_en;
        e.frm  = low_stop1;
        if (expect_it) q.push_back(e);
        drive_bit(1'b0, 0);
        for (int i = 0; i < nb; i++) drive_bit(dm[i], 0);
        if (cfg_par_en) drive_bit(pb, 0);
        if (low_stop1) drive_bit(1'b0, 40); else drive_bit(1'b1, 0);
        if (cfg_stop2) begin
            if (low_stop2) drive_bit(1'b0, 48); else drive_bit(1'b1, 0);
        end
        rx_line <= 1'b1;
        repeat (2 * BITCLK) @(posedge clk);
    endtask

    task automatic pulse_rd();
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic consume();
        pulse_rd();
        pulse_clr();
    endtask

    // monitor: each interrupt pops one expected item
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (!rst && rx_irq) begin
                if (q.size() == 0) begin
                    check(1'b0, "R9", "interrupt with no character expected", 1, 0);
                end else begin
                    e = q.pop_front();
                    check(rx_data == e.data, "R2", "rx_data at interrupt", rx_data, e.data);
                    check(rx_full == 1'b1, "R3", "rx_full with interrupt", rx_full, 1);
                    check(err_parity == e.par, "R5", "err_parity with interrupt", err_parity, e.par);
                    check(err_frame == e.frm, "R6", "err_frame with interrupt", err_frame, e.frm);
                    check(err_overrun == 1'b0, "R3", "err_overrun with interrupt", err_overrun, 0);
                end
                @(negedge clk);
                check(rx_irq == 1'b0, "R3", "interrupt lasts one cycle", rx_irq, 0);
            end
        end
    end

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(rx_full == 0 && rx_irq == 0, "R1", "full/irq after reset", {rx_full, rx_irq}, 0);
        check({err_overrun, err_parity, err_frame} == 0, "R1", "error flags after reset",
              {err_overrun, err_parity, err_frame}, 0);
        check(rx_data == 8'h00, "R1", "rx_data after reset", rx_data, 0);
        rst = 1'b0;
        repeat (3 * BITCLK) @(posedge clk);

        // R2: 8N1, LSB first
        send_frame(8'h4B, 0, 0, 0, 1); consume();
        send_frame(8'h81, 0, 0, 0, 1); consume();

        // R4: 7-bit length, bit 7 reads 0
        cfg_len8 = 1'b0;
        send_frame(8'hD5, 0, 0, 0, 1);
        check(rx_data[7] == 1'b0, "R4", "bit 7 in 7-bit mode", rx_data[7], 0);
        consume();
        send_frame(8'hFF, 0, 0, 0, 1); consume();
        cfg_len8 = 1'b1;

        // R5: even and odd parity, good and corrupted
        cfg_par_en = 1'b1;
        send_frame(8'h37, 0, 0, 0, 1); consume();
        send_frame(8'h37, 1, 0, 0, 1);
        repeat (BITCLK) @(posedge clk);
        @(negedge clk);
        check(err_parity == 1'b1, "R10", "parity flag still set before clear", err_parity, 1);
        pulse_clr();
        @(negedge clk);
        check(err_parity == 1'b0, "R10", "parity flag after clear", err_parity, 0);
        check(rx_full == 1'b1 && rx_data == 8'h37, "R10", "clear leaves buffer",
              {rx_full, rx_data}, {1'b1, 8'h37});
        pulse_rd();
        cfg_par_odd = 1'b1;
        send_frame(8'hC3, 0, 0, 0, 1); consume();
        send_frame(8'hC2, 1, 0, 0, 1); consume();
        cfg_par_en = 1'b0; cfg_par_odd = 1'b0;

        // R6: framing error on a low first stop bit
        send_frame(8'h5A, 0, 1, 0, 1); consume();

        // R7: false start glitch
        rx_line <= 1'b0;
        repeat (3 * TDIV) @(posedge clk);
        rx_line <= 1'b1;
        repeat (3 * BITCLK) @(posedge clk);
        @(negedge clk);
        check(rx_full == 1'b0, "R7", "glitch leaves buffer empty", rx_full, 0);
        check(rx_data == 8'h5A, "R7", "glitch leaves rx_data", rx_data, 8'h5A);
        send_frame(8'hE1, 0, 0, 0, 1); consume();

        // R8: two stop bits, second one low is not checked
        cfg_stop2 = 1'b1;
        send_frame(8'h96, 0, 0, 1, 1);
        check(err_frame == 1'b0, "R8", "low second stop bit ignored", err_frame, 0);
        consume();
        send_frame(8'h69, 0, 0, 0, 1); consume();
        cfg_stop2 = 1'b0;

        // R9: overrun keeps old buffer, no interrupt
        send_frame(8'h11, 0, 0, 0, 1);
        send_frame(8'h22, 0, 0, 0, 0);
        @(negedge clk);
        check(err_overrun == 1'b1, "R9", "overrun flag", err_overrun, 1);
        check(rx_data == 8'h11, "R9", "old character kept", rx_data, 8'h11);
        check(rx_full == 1'b1, "R9", "buffer still full", rx_full, 1);
        pulse_clr();
        @(negedge clk);
        check(err_overrun == 1'b0, "R10", "overrun after clear", err_overrun, 0);
        check(rx_full == 1'b1, "R10", "clear leaves rx_full", rx_full, 1);

        // R11: read clears full
        pulse_rd();
        @(negedge clk);
        check(rx_full == 1'b0, "R11", "full after read", rx_full, 0);

        send_frame(8'h3C, 0, 0, 0, 1); consume();
        repeat (20) @(posedge clk);
        check(q.size() == 0, "R3", "every expected character raised an interrupt", q.size(), 0);
        report();
    end
endmodule